// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block holds the request register of one eight-input interrupt controller. Every clock it samples the input lines and updates one request bit and one last-level bit for each line. Each line is set as edge or level triggered by its own bit in a trigger-mode register. Writes to that register pass through a write mask fixed per instance, so a line can be locked to edge triggering. Acknowledge logic clears the request of the line it has just served. An initialisation strobe resets the edge history. Priority resolution, in-service tracking and bus decoding belong to neighbouring blocks.

Each line also has a two-bit status code. It tells the caller whether an input event in the current cycle makes a new request, lands on a request that is already pending, or falls on a masked line. The status is combinational from the present inputs and the registered state. The request, last-level and trigger-mode registers change only on the rising clock edge.

Top module: `irql_latch`

## Requirements
- R1: A synchronous active-high reset clears the request, last-level and trigger-mode registers. From the next edge, `req` and `trig_mode` read all zeros.
- R2: On a line whose `trig_mode` bit is 1 (level), the request bit follows the sampled input level one edge later. A high input sets the bit and a low input clears it.
- R3: On a line whose `trig_mode` bit is 0 (edge), a high input sets the request bit only when the previously sampled level was low.
- R4: On an edge line, an input that stays high or goes low leaves a pending request bit set. The low level only clears the recorded last level.
- R5: A `trig_wr` pulse loads `trig_mode` with `trig_wdata` ANDed with the parameter `TRIG_WMASK`. Lines whose mask bit is 0 stay edge triggered.
- R6: `ack_vld` with line index `ack_idx` clears that line's request bit only when the line is edge triggered. A level line's request is not changed by the acknowledge.
- R7: When an acknowledge and a rising edge reach the same edge line in one cycle, the clear happens first and the rising edge then sets the request again, so the bit ends at 1.
- R8: An `init` pulse clears every last-level bit and every request bit on an edge line, and keeps the request bits of level lines. Input levels and acknowledges in that cycle have no effect on the request or last-level registers.
- R9: The status field of line i is `status[2*i+1:2*i]`. The codes are 2'b11 when `mask[i]` is 1, 2'b01 when an event occurs and the request bit is clear, 2'b10 when an event occurs and the request bit is already set, and 2'b00 when there is no event. An event is a high level on a level line, or a high level after a low one on an edge line.
- R10: The mask affects only the status. A masked line still latches its request as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| line_lvl | input | NLINES | Sampled interrupt input levels |
| mask | input | NLINES | Mask bits, one per line |
| trig_wr | input | 1 | Write strobe for the trigger-mode register |
| trig_wdata | input | NLINES | Trigger-mode write data (1 = level) |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_idx | input | IDXW | Index of the acknowledged line |
| init | input | 1 | Initialisation strobe |
| req | output | NLINES | Request register |
| trig_mode | output | NLINES | Trigger-mode register |
| status | output | 2*NLINES | Per-line status codes, two bits each |

## Verification
The bench builds two instances side by side, driven by the same inputs. One uses the write mask 8'hF8 and the other uses 8'hDE. A write of all ones therefore leaves lines 0 to 2 edge-locked on the first instance and lines 0 and 5 edge-locked on the second. Edge and level handling then differ between the two instances on the same line in the same cycle. Directed steps reach the acknowledge/edge collision, masked latching and initialisation. A long random phase then mixes every strobe against a behavioural reference model.

// File: rtl/irql_pkg.sv
package irql_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_NEW  = 2'b01,
        ST_PEND = 2'b10,
        ST_MASK = 2'b11
    } line_stat_e;
endpackage

// File: rtl/irql_line.sv
module irql_line
    import irql_pkg::*;
(
    input  logic       lvl_mode,
    input  logic       lvl_in,
    input  logic       last_q,
    input  logic       req_q,
    input  logic       ack_hit,
    input  logic       init,
    input  logic       masked,
    output logic       req_d,
    output logic       last_d,
    output line_stat_e stat
);
    logic rise;
    logic evt;
    logic req_acked;

    always_comb begin
        rise      = lvl_in & ~last_q;
        evt       = lvl_mode ? lvl_in : rise;
        // acknowledge clears only an edge request, applied before a new edge
        req_acked = req_q & ~(ack_hit & ~lvl_mode);

        if (init) begin
            last_d = 1'b0;
            req_d  = req_q & lvl_mode;
        end else if (lvl_mode) begin
            last_d = lvl_in;
            req_d  = lvl_in;
        end else begin
            last_d = lvl_in;
            req_d  = req_acked | rise;
        end

        if (masked)
            stat = ST_MASK;
        else if (evt)
            stat = req_q ? ST_PEND : ST_NEW;
        else
            stat = ST_IDLE;
    end
endmodule

// File: rtl/irql_latch.sv
module irql_latch
    import irql_pkg::*;
#(
    parameter int              NLINES     = 8,
    parameter int              IDXW       = (NLINES > 1) ? $clog2(NLINES) : 1,
    parameter logic [NLINES-1:0] TRIG_WMASK = 8'hF8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NLINES-1:0]   line_lvl,
    input  logic [NLINES-1:0]   mask,
    input  logic                trig_wr,
    input  logic [NLINES-1:0]   trig_wdata,
    input  logic                ack_vld,
    input  logic [IDXW-1:0]     ack_idx,
    input  logic                init,
    output logic [NLINES-1:0]   req,
    output logic [NLINES-1:0]   trig_mode,
    output logic [2*NLINES-1:0] status
);
    localparam int STW = 2 * NLINES;

    typedef struct packed {
        logic [NLINES-1:0] req;
        logic [NLINES-1:0] last;
        logic [NLINES-1:0] trig;
    } state_t;

    state_t st_d, st_q;

    logic [NLINES-1:0] ln_req_d;
    logic [NLINES-1:0] ln_last_d;
    logic [STW-1:0]    ln_stat;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        line_stat_e stat_i;

        irql_line u_line (
            .lvl_mode (st_q.trig[i]),
            .lvl_in   (line_lvl[i]),
            .last_q   (st_q.last[i]),
            .req_q    (st_q.req[i]),
            .ack_hit  (ack_vld && (ack_idx == IDXW'(i))),
            .init     (init),
            .masked   (mask[i]),
            .req_d    (ln_req_d[i]),
            .last_d   (ln_last_d[i]),
            .stat     (stat_i)
        );

        assign ln_stat[2*i +: 2] = stat_i;
    end

    always_comb begin
        st_d      = st_q;
        st_d.req  = ln_req_d;
        st_d.last = ln_last_d;
        if (trig_wr)
            st_d.trig = trig_wdata & TRIG_WMASK;
        if (rst)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign req       = st_q.req;
    assign trig_mode = st_q.trig;
    assign status    = ln_stat;
endmodule

// File: rtl/irql_chk.sv
module irql_chk #(
    parameter int                NLINES     = 8,
    parameter int                IDXW       = 3,
    parameter logic [NLINES-1:0] TRIG_WMASK = 8'hF8
) (
    input logic                clk,
    input logic                rst,
    input logic [NLINES-1:0]   line_lvl,
    input logic [NLINES-1:0]   mask,
    input logic                trig_wr,
    input logic [NLINES-1:0]   trig_wdata,
    input logic                ack_vld,
    input logic [IDXW-1:0]     ack_idx,
    input logic                init,
    input logic [NLINES-1:0]   req,
    input logic [NLINES-1:0]   trig_mode,
    input logic [2*NLINES-1:0] status
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (req == '0 && trig_mode == '0));

    p_trig_write_r5: assert property (@(posedge clk) disable iff (rst)
        trig_wr |=> trig_mode == ($past(trig_wdata) & TRIG_WMASK));

    for (genvar i = 0; i < NLINES; i++) begin : g_chk
        p_level_follow_r2: assert property (@(posedge clk) disable iff (rst)
            (!init && trig_mode[i]) |=> req[i] == $past(line_lvl[i]));

        p_new_sets_r3: assert property (@(posedge clk) disable iff (rst)
            (!init && !mask[i] && status[2*i +: 2] == 2'b01) |=> req[i]);

        p_edge_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (!init && !trig_mode[i] && req[i]
             && !(ack_vld && ack_idx == IDXW'(i))) |=> req[i]);

        p_edge_ack_r6: assert property (@(posedge clk) disable iff (rst)
            (ack_vld && ack_idx == IDXW'(i) && !init && !trig_mode[i]
             && !line_lvl[i]) |=> !req[i]);

        p_init_edge_r8: assert property (@(posedge clk) disable iff (rst)
            (init && !trig_mode[i]) |=> !req[i]);

        p_init_level_r8: assert property (@(posedge clk) disable iff (rst)
            (init && trig_mode[i]) |=> req[i] == $past(req[i]));

        p_mask_code_r9: assert property (@(posedge clk) disable iff (rst)
            mask[i] |-> status[2*i +: 2] == 2'b11);
    end
endmodule

bind irql_latch irql_chk #(
    .NLINES     (NLINES),
    .IDXW       (IDXW),
    .TRIG_WMASK (TRIG_WMASK)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_lvl   (line_lvl),
    .mask       (mask),
    .trig_wr    (trig_wr),
    .trig_wdata (trig_wdata),
    .ack_vld    (ack_vld),
    .ack_idx    (ack_idx),
    .init       (init),
    .req        (req),
    .trig_mode  (trig_mode),
    .status     (status)
);

// File: tb/sim_irql_latch.sv
module sim_irql_latch;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] WM [2] = '{8'hF8, 8'hDE};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] lvl = '0;
    logic [7:0] msk = '0;
    logic       wr = 1'b0;
    logic [7:0] wdat = '0;
    logic       ack = 1'b0;
    logic [2:0] aidx = '0;
    logic       ini = 1'b0;

    logic [7:0]  req0, trig0, req1, trig1;
    logic [15:0] stat0, stat1;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_req  [2];
    logic [7:0] m_last [2];
    logic [7:0] m_trig [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    irql_latch #(.TRIG_WMASK(8'hF8)) u0 (
        .clk(clk), .rst(rst), .line_lvl(lvl), .mask(msk), .trig_wr(wr),
        .trig_wdata(wdat), .ack_vld(ack), .ack_idx(aidx), .init(ini),
        .req(req0), .trig_mode(trig0), .status(stat0)
    );

    irql_latch #(.TRIG_WMASK(8'hDE)) u1 (
        .clk(clk), .rst(rst), .line_lvl(lvl), .mask(msk), .trig_wr(wr),
        .trig_wdata(wdat), .ack_vld(ack), .ack_idx(aidx), .init(ini),
        .req(req1), .trig_mode(trig1), .status(stat1)
    );

    task automatic check(string tag, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_stat(int k);
        logic [15:0] s = '0;
        for (int i = 0; i < 8; i++) begin
            bit ev = m_trig[k][i] ? lvl[i] : (lvl[i] && !m_last[k][i]);
            if (msk[i])      s[2*i +: 2] = 2'b11;
            else if (ev)     s[2*i +: 2] = m_req[k][i] ? 2'b10 : 2'b01;
            else             s[2*i +: 2] = 2'b00;
        end
        return s;
    endfunction

    task automatic model_edge();
        for (int k = 0; k < 2; k++) begin
            if (rst) begin
                m_req[k] = '0; m_last[k] = '0; m_trig[k] = '0;
            end else begin
                if (ini) begin
                    m_last[k] = '0;
                    m_req[k]  = m_req[k] & m_trig[k];
                end else begin
                    for (int i = 0; i < 8; i++) begin
                        if (m_trig[k][i]) begin
                            m_req[k][i] = lvl[i];
                        end else begin
                            if (ack && aidx == 3'(i)) m_req[k][i] = 1'b0;
                            if (lvl[i] && !m_last[k][i]) m_req[k][i] = 1'b1;
                        end
                        m_last[k][i] = lvl[i];
                    end
                end
                if (wr) m_trig[k] = wdat & WM[k];
            end
        end
    endtask

    task automatic step(string tag);
        @(negedge clk);
        if (!rst) begin
            check(tag, "u0 status", int'(stat0), int'(exp_stat(0)));
            check(tag, "u1 status", int'(stat1), int'(exp_stat(1)));
        end
        @(posedge clk);
        model_edge();
        #1;
        check(tag, "u0 req",  int'(req0),  int'(m_req[0]));
        check(tag, "u0 trig", int'(trig0), int'(m_trig[0]));
        check(tag, "u1 req",  int'(req1),  int'(m_req[1]));
        check(tag, "u1 trig", int'(trig1), int'(m_trig[1]));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_req[k] = '0; m_last[k] = '0; m_trig[k] = '0;
        end
        // R1: reset state
        rst = 1'b1;
        for (int n = 0; n < 3; n++) step("R1");
        rst = 1'b0;

        // R5: all-ones write lands through each instance mask
        wr = 1'b1; wdat = 8'hFF; step("R5");
        wr = 1'b0;

        // R2: level line 3 follows its input
        lvl = 8'h08; step("R2");
        lvl = 8'h00; step("R2");

        // R3/R4: edge line 0 sets once, holds while high and after going low
        lvl = 8'h01; step("R3");
        step("R4");
        lvl = 8'h00; step("R4");

        // R6: ack on level line keeps request, ack on edge line clears it
        lvl = 8'h08; step("R6");
        ack = 1'b1; aidx = 3'd3; step("R6");
        aidx = 3'd0; step("R6");
        ack = 1'b0;

        // R7: ack and rising edge on the same edge line
        lvl = 8'h09; step("R7");
        lvl = 8'h08; step("R7");
        lvl = 8'h09; ack = 1'b1; aidx = 3'd0; step("R7");
        ack = 1'b0;

        // R10: masked edge line 1 still latches
        lvl = 8'h0B; msk = 8'h02; step("R10");
        msk = 8'h00; step("R9");
        lvl = 8'h09; step("R9");
        lvl = 8'h0B; step("R9");

        // R8: init drops edge requests and history, keeps level ones
        ini = 1'b1; step("R8");
        ini = 1'b0; step("R8");

        // mixed random traffic (R4 and all others through the model)
        for (int n = 0; n < 600; n++) begin
            lvl  = 8'($urandom);
            msk  = 8'($urandom);
            wr   = ($urandom % 16) == 0;
            wdat = 8'($urandom);
            ack  = ($urandom % 3) == 0;
            aidx = 3'($urandom);
            ini  = ($urandom % 40) == 0;
            rst  = ($urandom % 150) == 0;
            step("R4");
        end
        rst = 1'b0; ini = 1'b0; ack = 1'b0; wr = 1'b0;
        step("R2");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule